// File: doc/BRIEF.md
# In-System Serial Programming Target

This block is the target-side responder for in-system programming over a three-wire serial link: a clock (`sck`) and a data input (`mosi`) from the host, and a data output (`miso`) back to it. It works only while the session pin `hold_n` is held low. The system clock `clk` oversamples the serial clock. Every instruction is exactly four bytes. The block assembles each instruction and decodes it into actions on small register-array models of a word-wide program memory with a page buffer, a byte-wide data EEPROM, a lock byte, two configuration (fuse) bytes and a four-byte signature.

A host opens a session by pulling `hold_n` low and sending the enable instruction. It confirms byte alignment by checking that the second byte comes back while the third byte is being sent. It can then load the page buffer word by word, commit it to a page, write EEPROM bytes, erase everything, and read any location back. Writes and erases start a self-timed busy window whose length, in system clocks, is a parameter. While the window is open, reads of the location being written return 0xFF, so the host can poll for completion.

Top module: `isp_target`

## Requirements
- R1: While `hold_n` is high, every instruction is ignored. After `hold_n` goes low, only the enable instruction (0xAC, 0x53, any, any) takes effect until one has completed. A read before that point answers with the echo of byte 3 rather than data. Raising `hold_n` withdraws the enable.
- R2: Raising `hold_n` clears the bit and byte counters, so a partly shifted instruction is discarded and the next session starts at byte 1.
- R3: During byte 3 of any instruction, `miso` returns byte 2, so an aligned enable answers 0x53. During bytes 2 and 4 of a non-read instruction, `miso` returns the byte just before.
- R4: `mosi` is sampled on the rising edge of `sck`. `miso` changes only after a falling edge of `sck` or when the session ends. Both directions send the most significant bit first.
- R5: Instruction 0x40 (low byte) or 0x48 (high byte) writes byte 4 into the page buffer word selected by the low OFS_W bits of byte 3 (default 3 bits, 8 words per page).
- R6: Instruction 0x4C commits the whole page buffer to the page selected by the bits above OFS_W of the word address {byte2[3:0], byte3}. After the commit, every buffer byte returns to 0xFF.
- R7: Instruction 0x20 (low byte) or 0x28 (high byte) returns, during byte 4, the program word at address {byte2[3:0], byte3}, taken modulo the memory size.
- R8: Instruction 0xC0 writes byte 4 to, and instruction 0xA0 reads from, the EEPROM address {byte2[0], byte3}, taken modulo the depth. A write replaces the old byte without a prior erase.
- R9: A page commit starts a busy window of FLASH_BUSY clocks, an EEPROM write one of EE_BUSY clocks, and an erase one of ERASE_BUSY clocks. While the window is open, reads inside the page or byte being written return 0xFF, and any further commit, EEPROM write or erase is dropped.
- R10: Chip erase (0xAC, then 100x xxxx) sets every program and EEPROM byte to 0xFF and every lock bit to 1.
- R11: Lock write (0xAC, 111x xxxx) can only clear lock bits: the lock byte becomes lock AND byte4[5:0]. It is read with 0x58/0x00 as {2'b11, lock}. Fuse writes 0xAC/0xA0 (low) and 0xAC/0xA8 (high) store byte 4. They are read with 0x50/0x00 and 0x58/0x08.
- R12: Instruction 0x30 returns signature byte byte3[1:0], where byte 0 is SIG[7:0].
- R13: After system reset, `miso` is 0, all program and EEPROM bytes are 0xFF, the lock bits are all 1, and the fuses hold FUSE_LO_INIT and FUSE_HI_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Synchronous active-low system reset |
| hold_n | input | 1 | Session pin; low enables programming |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
Two events can land in the same system clock. One is the end of a busy window, when the counter expires. The other is the byte-3 read lookup, or the decode of a new write, by a host that polls back to back. The bench provokes this by polling a just-written page or EEPROM byte repeatedly and by issuing a second EEPROM write inside the first one's window. It judges that each poll returns either 0xFF or the exact written value, that polling ends with the written value, and that the early second write leaves its target at 0xFF.

// File: rtl/isp_pkg.sv
// Package: shared opcodes, busy kinds and the four-byte instruction record
// for the serial programming target. Assumes the fixed four-byte framing.
package isp_pkg;
    localparam logic [7:0] OP_SPECIAL = 8'hAC;
    localparam logic [7:0] OP_ENABLE2 = 8'h53;
    localparam logic [7:0] OP_LD_LO   = 8'h40;
    localparam logic [7:0] OP_LD_HI   = 8'h48;
    localparam logic [7:0] OP_COMMIT  = 8'h4C;
    localparam logic [7:0] OP_RD_LO   = 8'h20;
    localparam logic [7:0] OP_RD_HI   = 8'h28;
    localparam logic [7:0] OP_EE_RD   = 8'hA0;
    localparam logic [7:0] OP_EE_WR   = 8'hC0;
    localparam logic [7:0] OP_RD_LKFH = 8'h58;
    localparam logic [7:0] OP_RD_FLO  = 8'h50;
    localparam logic [7:0] OP_RD_SIG  = 8'h30;
    localparam logic [7:0] OP_WR_FLO  = 8'hA0;
    localparam logic [7:0] OP_WR_FHI  = 8'hA8;

    typedef enum logic [1:0] {BZ_IDLE, BZ_FLASH, BZ_EEPROM, BZ_ERASE} busy_kind_t;

    typedef struct packed {
        logic [7:0] b1;
        logic [7:0] b2;
        logic [7:0] b3;
        logic [7:0] b4;
    } instr_t;
endpackage

// File: rtl/isp_sync.sv
// Module: multi-stage synchroniser for asynchronous serial-link inputs.
// Assumes inputs change slowly relative to clk; reset loads RST_VAL.
module isp_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // Purpose: shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/isp_shifter.sv
// Module: serial byte engine. Detects SCK edges in the clk domain, shifts
// MOSI in on rising edges, drives MISO on falling edges (MSB first), counts
// bits and bytes, and pulses exec when the fourth byte of an instruction
// completes. Assumes synchronised inputs; session end clears all counters.
module isp_shifter
    import isp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       sck_s,
    input  logic       mosi_s,
    input  logic       rd_hit,
    input  logic [7:0] rd_byte,
    output logic [7:0] cur_byte,
    output logic       exec,
    output instr_t     instr,
    output logic       miso
);
    localparam int BYTE_BITS = 8;
    localparam int NBYTES    = 4;
    localparam int BC_W      = $clog2(BYTE_BITS);
    localparam int IX_W      = $clog2(NBYTES);

    logic            sck_q;
    logic            rise, fall, byte_end;
    logic [BC_W-1:0] bit_cnt;
    logic [IX_W-1:0] byte_idx;
    logic [7:0]      rx, tx;

    assign rise     = sck_s & ~sck_q;
    assign fall     = ~sck_s & sck_q;
    assign cur_byte = {rx[6:0], mosi_s};
    assign byte_end = active & rise & (bit_cnt == BC_W'(BYTE_BITS-1));

    // Purpose: remember the previous synchronised SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Purpose: assemble received bits into bytes and bytes into an instruction.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            bit_cnt  <= '0;
            byte_idx <= '0;
            rx       <= '0;
            exec     <= 1'b0;
            instr    <= '0;
        end else begin
            exec <= 1'b0;
            if (rise) begin
                rx      <= cur_byte;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BC_W'(BYTE_BITS-1)) begin
                    byte_idx <= byte_idx + 1'b1;
                    case (byte_idx)
                        2'd0: instr.b1 <= cur_byte;
                        2'd1: instr.b2 <= cur_byte;
                        2'd2: instr.b3 <= cur_byte;
                        default: begin
                            instr.b4 <= cur_byte;
                            exec     <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    // Purpose: load the outgoing byte at byte ends and shift it out on falls.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            tx   <= '0;
            miso <= 1'b0;
        end else if (byte_end) begin
            tx <= (byte_idx == IX_W'(2) && rd_hit) ? rd_byte : cur_byte;
        end else if (fall) begin
            miso <= tx[7];
            tx   <= {tx[6:0], 1'b0};
        end
    end

    // R4: MISO moves only after a falling SCK edge or at session end
    a_r4_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> ($past(fall) || !$past(active)));
    // R3: an instruction completes in a single-cycle pulse
    a_r3_exec_single: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> !exec);
    // R2: after an instruction the byte counter is back at byte 1
    a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        exec |-> (byte_idx == '0 && bit_cnt == '0));
endmodule

// File: rtl/isp_store.sv
// Module: instruction decoder and memory models. Holds program memory,
// page buffer, EEPROM, lock and fuse bytes, the session enable and a single
// busy timer. Supplies read data for the byte-3 lookup. Assumes PAGES >= 2
// and OFS_W + page bits <= 12 so the word address fits the instruction.
module isp_store
    import isp_pkg::*;
#(
    parameter int          OFS_W        = 3,
    parameter int          PAGES        = 4,
    parameter int          EE_DEPTH     = 16,
    parameter int          FLASH_BUSY   = 600,
    parameter int          EE_BUSY      = 800,
    parameter int          ERASE_BUSY   = 800,
    parameter logic [7:0]  FUSE_LO_INIT = 8'hE1,
    parameter logic [7:0]  FUSE_HI_INIT = 8'h99,
    parameter logic [31:0] SIG          = 32'h0F3CA5E1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       exec,
    input  instr_t     instr,
    input  logic [7:0] cur_byte,
    output logic       rd_hit,
    output logic [7:0] rd_byte
);
    localparam int PAGE_W     = $clog2(PAGES);
    localparam int WA_W       = OFS_W + PAGE_W;
    localparam int WORDS      = 1 << WA_W;
    localparam int PAGE_WORDS = 1 << OFS_W;
    localparam int EA_W       = $clog2(EE_DEPTH);
    localparam int MAX_BUSY   = (FLASH_BUSY > EE_BUSY) ?
                                ((FLASH_BUSY > ERASE_BUSY) ? FLASH_BUSY : ERASE_BUSY) :
                                ((EE_BUSY > ERASE_BUSY) ? EE_BUSY : ERASE_BUSY);
    localparam int CNT_W      = $clog2(MAX_BUSY + 1);

    logic [15:0]       pm   [WORDS];
    logic [15:0]       pbuf [PAGE_WORDS];
    logic [7:0]        ee   [EE_DEPTH];
    logic [5:0]        lock;
    logic [7:0]        fuse_lo, fuse_hi;
    logic              enabled;
    busy_kind_t        busy_kind;
    logic [CNT_W-1:0]  busy_cnt;
    logic [PAGE_W-1:0] busy_page;
    logic [EA_W-1:0]   busy_ea;
    logic              busy;

    // Decode fields of the completed instruction.
    logic [11:0]       xwa;
    logic [8:0]        xea9;
    logic [PAGE_W-1:0] xpage;
    logic [OFS_W-1:0]  xofs;
    logic [EA_W-1:0]   xea;
    logic              go, is_enable, is_erase, is_wlock, is_wflo, is_wfhi;

    assign busy      = (busy_kind != BZ_IDLE);
    assign xwa       = {instr.b2[3:0], instr.b3};
    assign xpage     = xwa[WA_W-1:OFS_W];
    assign xofs      = instr.b3[OFS_W-1:0];
    assign xea9      = {instr.b2[0], instr.b3};
    assign xea       = xea9[EA_W-1:0];
    assign go        = exec && enabled;
    assign is_enable = (instr.b1 == OP_SPECIAL) && (instr.b2 == OP_ENABLE2);
    assign is_erase  = (instr.b1 == OP_SPECIAL) && (instr.b2[7:5] == 3'b100);
    assign is_wlock  = (instr.b1 == OP_SPECIAL) && (instr.b2[7:5] == 3'b111);
    assign is_wflo   = (instr.b1 == OP_SPECIAL) && (instr.b2 == OP_WR_FLO);
    assign is_wfhi   = (instr.b1 == OP_SPECIAL) && (instr.b2 == OP_WR_FHI);

    // Purpose: track the session enable, set by a completed enable instruction.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)       enabled <= 1'b0;
        else if (exec && is_enable)  enabled <= 1'b1;
    end

    // Purpose: run the busy timer and apply memory, lock and fuse updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++)      pm[i]   <= 16'hFFFF;
            for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= 16'hFFFF;
            for (int i = 0; i < EE_DEPTH; i++)   ee[i]   <= 8'hFF;
            lock      <= 6'h3F;
            fuse_lo   <= FUSE_LO_INIT;
            fuse_hi   <= FUSE_HI_INIT;
            busy_kind <= BZ_IDLE;
            busy_cnt  <= '0;
            busy_page <= '0;
            busy_ea   <= '0;
        end else begin
            if (busy) begin
                if (busy_cnt == CNT_W'(1)) begin
                    busy_kind <= BZ_IDLE;
                    busy_cnt  <= '0;
                end else begin
                    busy_cnt <= busy_cnt - 1'b1;
                end
            end
            if (go) begin
                if (instr.b1 == OP_LD_LO) pbuf[xofs][7:0]  <= instr.b4;
                if (instr.b1 == OP_LD_HI) pbuf[xofs][15:8] <= instr.b4;
                if (instr.b1 == OP_COMMIT && !busy) begin
                    for (int k = 0; k < PAGE_WORDS; k++) begin
                        pm[WA_W'(int'(xpage) * PAGE_WORDS + k)] <= pbuf[k];
                        pbuf[k] <= 16'hFFFF;
                    end
                    busy_kind <= BZ_FLASH;
                    busy_cnt  <= CNT_W'(FLASH_BUSY);
                    busy_page <= xpage;
                end
                if (instr.b1 == OP_EE_WR && !busy) begin
                    ee[xea]   <= instr.b4;
                    busy_kind <= BZ_EEPROM;
                    busy_cnt  <= CNT_W'(EE_BUSY);
                    busy_ea   <= xea;
                end
                if (is_erase && !busy) begin
                    for (int i = 0; i < WORDS; i++)    pm[i] <= 16'hFFFF;
                    for (int i = 0; i < EE_DEPTH; i++) ee[i] <= 8'hFF;
                    lock      <= 6'h3F;
                    busy_kind <= BZ_ERASE;
                    busy_cnt  <= CNT_W'(ERASE_BUSY);
                end
                if (is_wlock) lock    <= lock & instr.b4[5:0];
                if (is_wflo)  fuse_lo <= instr.b4;
                if (is_wfhi)  fuse_hi <= instr.b4;
            end
        end
    end

    // Read lookup fields: bytes 1-2 are held, byte 3 is the one finishing.
    logic [11:0]       rwa;
    logic [WA_W-1:0]   rword;
    logic [PAGE_W-1:0] rpage;
    logic [8:0]        rea9;
    logic [EA_W-1:0]   rea;

    assign rwa   = {instr.b2[3:0], cur_byte};
    assign rword = rwa[WA_W-1:0];
    assign rpage = rwa[WA_W-1:OFS_W];
    assign rea9  = {instr.b2[0], cur_byte};
    assign rea   = rea9[EA_W-1:0];

    // Purpose: choose the byte returned in byte 4 of a read instruction.
    always_comb begin
        rd_hit  = 1'b0;
        rd_byte = 8'hFF;
        if (enabled) begin
            case (instr.b1)
                OP_RD_LO, OP_RD_HI: begin
                    rd_hit = 1'b1;
                    if (!(busy_kind == BZ_FLASH && rpage == busy_page))
                        rd_byte = (instr.b1 == OP_RD_HI) ? pm[rword][15:8] : pm[rword][7:0];
                end
                OP_EE_RD: begin
                    rd_hit = 1'b1;
                    if (!(busy_kind == BZ_EEPROM && rea == busy_ea))
                        rd_byte = ee[rea];
                end
                OP_RD_LKFH: begin
                    if (instr.b2 == 8'h00) begin
                        rd_hit  = 1'b1;
                        rd_byte = {2'b11, lock};
                    end else if (instr.b2 == 8'h08) begin
                        rd_hit  = 1'b1;
                        rd_byte = fuse_hi;
                    end
                end
                OP_RD_FLO: begin
                    if (instr.b2 == 8'h00) begin
                        rd_hit  = 1'b1;
                        rd_byte = fuse_lo;
                    end
                end
                OP_RD_SIG: begin
                    rd_hit  = 1'b1;
                    rd_byte = SIG[{cur_byte[1:0], 3'b000} +: 8];
                end
                default: ;
            endcase
        end
    end

    // R1: the enable only rises right after a completed instruction
    a_r1_enable_from_instr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enabled) |-> $past(exec));
    // R9: a busy window only opens right after a completed instruction
    a_r9_busy_from_instr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(exec));
    // R9: an open busy window always has time left
    a_r9_busy_counting: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cnt != '0);
endmodule

// File: rtl/isp_target.sv
// Module: top of the serial programming target. Synchronises the link pins,
// then connects the byte engine to the decoder and memory models.
// Assumes hold_n low marks a programming session.
module isp_target #(
    parameter int          OFS_W        = 3,
    parameter int          PAGES        = 4,
    parameter int          EE_DEPTH     = 16,
    parameter int          FLASH_BUSY   = 600,
    parameter int          EE_BUSY      = 800,
    parameter int          ERASE_BUSY   = 800,
    parameter logic [7:0]  FUSE_LO_INIT = 8'hE1,
    parameter logic [7:0]  FUSE_HI_INIT = 8'h99,
    parameter logic [31:0] SIG          = 32'h0F3CA5E1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    import isp_pkg::*;

    logic [2:0] pins_s;
    logic       active, rd_hit, exec;
    logic [7:0] rd_byte, cur_byte;
    instr_t     instr;

    isp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({hold_n, sck, mosi}), .q(pins_s));

    assign active = ~pins_s[2];

    isp_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .active(active),
        .sck_s(pins_s[1]), .mosi_s(pins_s[0]),
        .rd_hit(rd_hit), .rd_byte(rd_byte), .cur_byte(cur_byte),
        .exec(exec), .instr(instr), .miso(miso));

    isp_store #(
        .OFS_W(OFS_W), .PAGES(PAGES), .EE_DEPTH(EE_DEPTH),
        .FLASH_BUSY(FLASH_BUSY), .EE_BUSY(EE_BUSY), .ERASE_BUSY(ERASE_BUSY),
        .FUSE_LO_INIT(FUSE_LO_INIT), .FUSE_HI_INIT(FUSE_HI_INIT), .SIG(SIG)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .active(active), .exec(exec),
        .instr(instr), .cur_byte(cur_byte),
        .rd_hit(rd_hit), .rd_byte(rd_byte));
endmodule

// File: tb/isp_target_tb.sv
module isp_target_tb;
    localparam logic [31:0] SIGV = 32'h0F3CA5E1;

    logic clk = 1'b0, rst_n = 1'b0, hold_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso;
    int   n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    isp_target u_dut (.clk(clk), .rst_n(rst_n), .hold_n(hold_n),
                      .sck(sck), .mosi(mosi), .miso(miso));

    always #2 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            sck  = 1'b0;
            tick(6);
            rx[i] = miso;
            sck  = 1'b1;
            tick(6);
        end
    endtask

    task automatic cmd(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input logic [7:0] d, output logic [7:0] r3, output logic [7:0] r4);
        logic [7:0] t;
        xfer(a, t);
        xfer(b, t);
        xfer(c, r3);
        xfer(d, r4);
    endtask

    function automatic logic [7:0] pat(input int w, input int hi);
        return 8'((w * 29 + hi * 113 + 7) & 255);
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

    initial begin
        logic [7:0] r3, r4, t;
        logic       hit;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check("R13 miso after reset", {15'd0, miso}, 16'd0);

        // R1: ignored while hold_n high
        cmd(8'hAC, 8'h53, 8'h00, 8'h00, r3, r4);
        hold_n = 1'b0;
        tick(10);
        // R1: write before enable is dropped; read before enable echoes byte 3
        cmd(8'hC0, 8'h00, 8'h05, 8'h3C, r3, r4);
        tick(1000);
        cmd(8'hA0, 8'h00, 8'h05, 8'h00, r3, r4);
        check("R1 read before enable echoes byte3", {8'd0, r4}, 16'h0005);
        cmd(8'hAC, 8'h53, 8'h00, 8'h00, r3, r4);
        check("R3 R4 enable echo", {8'd0, r3}, 16'h0053);
        cmd(8'hA0, 8'h00, 8'h05, 8'h00, r3, r4);
        check("R1 R13 early write ignored", {8'd0, r4}, 16'h00FF);
        cmd(8'h50, 8'h00, 8'h00, 8'h00, r3, r4);
        check("R13 fuse low default", {8'd0, r4}, 16'h00E1);
        cmd(8'h58, 8'h08, 8'h00, 8'h00, r3, r4);
        check("R13 fuse high default", {8'd0, r4}, 16'h0099);
        cmd(8'h58, 8'h00, 8'h00, 8'h00, r3, r4);
        check("R13 lock default", {8'd0, r4}, 16'h00FF);
        cmd(8'h20, 8'h00, 8'h07, 8'h00, r3, r4);
        check("R13 program memory erased", {8'd0, r4}, 16'h00FF);
        check("R3 echo byte2 on plain read", {8'd0, r3}, 16'h0000);

        // R5 R6 R9: fill each page, poll until commit completes
        for (int p = 0; p < 4; p++) begin
            for (int o = 0; o < 8; o++) begin
                cmd(8'h40, 8'h00, 8'(o), pat(p * 8 + o, 0), r3, r4);
                cmd(8'h48, 8'h00, 8'(o), pat(p * 8 + o, 1), r3, r4);
            end
            cmd(8'h4C, 8'h00, 8'(p * 8), 8'h00, r3, r4);
            cmd(8'h20, 8'h00, 8'(p * 8 + 3), 8'h00, r3, r4);
            check("R9 page busy reads FF", {8'd0, r4}, 16'h00FF);
            hit = 1'b0;
            for (int k = 0; k < 6 && !hit; k++) begin
                cmd(8'h20, 8'h00, 8'(p * 8 + 3), 8'h00, r3, r4);
                if (r4 === pat(p * 8 + 3, 0)) hit = 1'b1;
                else if (r4 !== 8'hFF) check("R9 poll value FF or data", {8'd0, r4}, {8'd0, pat(p * 8 + 3, 0)});
            end
            check("R9 poll completes", {15'd0, hit}, 16'd1);
        end
        // R7: read back every word, both bytes
        for (int w = 0; w < 32; w++) begin
            cmd(8'h20, 8'h00, 8'(w), 8'h00, r3, r4);
            check("R7 R5 low byte", {8'd0, r4}, {8'd0, pat(w, 0)});
            cmd(8'h28, 8'h00, 8'(w), 8'h00, r3, r4);
            check("R7 R5 high byte", {8'd0, r4}, {8'd0, pat(w, 1)});
        end
        // R7: address taken modulo memory size
        cmd(8'h28, 8'h01, 8'd37, 8'h00, r3, r4);
        check("R7 address wraps", {8'd0, r4}, {8'd0, pat(5, 1)});
        // R6: buffer cleared after commit
        cmd(8'h40, 8'h00, 8'h02, 8'h12, r3, r4);
        cmd(8'h4C, 8'h00, 8'h08, 8'h00, r3, r4);
        tick(800);
        cmd(8'h20, 8'h00, 8'h0A, 8'h00, r3, r4);
        check("R6 new low byte", {8'd0, r4}, 16'h0012);
        cmd(8'h28, 8'h00, 8'h0A, 8'h00, r3, r4);
        check("R6 cleared high byte", {8'd0, r4}, 16'h00FF);
        cmd(8'h20, 8'h00, 8'h09, 8'h00, r3, r4);
        check("R6 cleared other word", {8'd0, r4}, 16'h00FF);
        cmd(8'h20, 8'h00, 8'h11, 8'h00, r3, r4);
        check("R6 other page untouched", {8'd0, r4}, {8'd0, pat(17, 0)});

        // R9: second write inside busy window dropped
        cmd(8'hC0, 8'h00, 8'h03, 8'h11, r3, r4);
        cmd(8'hC0, 8'h00, 8'h04, 8'h22, r3, r4);
        tick(1000);
        cmd(8'hA0, 8'h00, 8'h04, 8'h00, r3, r4);
        check("R9 write during busy dropped", {8'd0, r4}, 16'h00FF);
        cmd(8'hA0, 8'h00, 8'h03, 8'h00, r3, r4);
        check("R8 first write kept", {8'd0, r4}, 16'h0011);

        // R8: sweep EEPROM
        for (int a = 0; a < 16; a++) begin
            cmd(8'hC0, 8'h00, 8'(a), 8'(a * 7 + 48), r3, r4);
            tick(900);
        end
        for (int a = 0; a < 16; a++) begin
            cmd(8'hA0, 8'h00, 8'(a), 8'h00, r3, r4);
            check("R8 eeprom readback", {8'd0, r4}, 16'(a * 7 + 48));
        end
        cmd(8'hC0, 8'h01, 8'h05, 8'h81, r3, r4);
        cmd(8'hA0, 8'h00, 8'h05, 8'h00, r3, r4);
        check("R9 eeprom busy reads FF", {8'd0, r4}, 16'h00FF);
        tick(900);
        cmd(8'hA0, 8'h00, 8'h15, 8'h00, r3, r4);
        check("R8 overwrite without erase", {8'd0, r4}, 16'h0081);

        // R11: lock and fuses
        cmd(8'hAC, 8'hE0, 8'h00, 8'hF5, r3, r4);
        cmd(8'hAC, 8'hE0, 8'h00, 8'hFF, r3, r4);
        cmd(8'h58, 8'h00, 8'h00, 8'h00, r3, r4);
        check("R11 lock only clears", {8'd0, r4}, 16'h00F5);
        cmd(8'hAC, 8'hA0, 8'h00, 8'h5A, r3, r4);
        cmd(8'h50, 8'h00, 8'h00, 8'h00, r3, r4);
        check("R11 fuse low write", {8'd0, r4}, 16'h005A);
        cmd(8'hAC, 8'hA8, 8'h00, 8'hC3, r3, r4);
        cmd(8'h58, 8'h08, 8'h00, 8'h00, r3, r4);
        check("R11 fuse high write", {8'd0, r4}, 16'h00C3);

        // R12: signature bytes
        for (int b = 0; b < 4; b++) begin
            cmd(8'h30, 8'h00, 8'(b), 8'h00, r3, r4);
            check("R12 signature", {8'd0, r4}, {8'd0, 8'(SIGV >> (8 * b))});
        end

        // R10: chip erase
        cmd(8'hAC, 8'h80, 8'h00, 8'h00, r3, r4);
        tick(1000);
        cmd(8'h20, 8'h00, 8'h05, 8'h00, r3, r4);
        check("R10 program erased", {8'd0, r4}, 16'h00FF);
        cmd(8'hA0, 8'h00, 8'h03, 8'h00, r3, r4);
        check("R10 eeprom erased", {8'd0, r4}, 16'h00FF);
        cmd(8'h58, 8'h00, 8'h00, 8'h00, r3, r4);
        check("R10 lock reset", {8'd0, r4}, 16'h00FF);

        // R2 R1: abort mid-instruction, then new session
        xfer(8'hAC, t);
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1; sck = 1'b0; tick(6); sck = 1'b1; tick(6);
        end
        sck = 1'b0;
        hold_n = 1'b1;
        tick(20);
        hold_n = 1'b0;
        tick(10);
        cmd(8'hC0, 8'h00, 8'h07, 8'h44, r3, r4);
        tick(1000);
        cmd(8'hAC, 8'h53, 8'h00, 8'h00, r3, r4);
        check("R2 realigned after session end", {8'd0, r3}, 16'h0053);
        cmd(8'hA0, 8'h00, 8'h07, 8'h00, r3, r4);
        check("R1 enable withdrawn by session end", {8'd0, r4}, 16'h00FF);

        done = 1'b1;
        report();
    end
endmodule